// File: doc/BRIEF.md
# Chip-Select Power Mode Controller

This block tracks the power state of a dual-channel sampling converter's serial port. It watches an active-low chip select and a serial clock. The power state changes only according to how many serial-clock falling edges have passed when chip select returns high. Short chip-select glitches are filtered out, so they cannot put the part to sleep or wake it by accident. A frame that is cut short in the middle of the data phase reports an aborted conversion. A frame that is cut short early puts the part into a deeper sleep level.

Waking up takes a dummy frame. The frame must hold chip select low through the tenth falling edge. The block then shows a wake-in-progress state for a programmable number of system-clock cycles before it returns to normal. The delay is short when waking from partial power-down and longer when waking from full power-down.

Both serial inputs are assumed to be already synchronous to the system clock `clk`. Each one is sampled once per cycle, and a falling edge is seen as a high sample followed by a low sample. The mode code uses these values:

| Code | State | Name in the design |
|------|-------|--------------------|
| 2'b00 | normal | `PM_NORMAL` |
| 2'b01 | partial power-down | `PM_PARTIAL` |
| 2'b10 | full power-down | `PM_FULL` |
| 2'b11 | waking | `PM_WAKING` |

The named transitions are:
- **sleep-light**: normal to partial.
- **sleep-deep**: partial to full.
- **wake-light**: partial to waking.
- **wake-deep**: full to waking.
- **ready**: waking to normal.

Top module: `cs_power_mode_ctrl`

## Requirements
- R1: An active-low asynchronous reset, when asserted, puts the block in normal mode and clears the edge count. In normal mode `mode_code` is 2'b00, `powered_up` is 1, `powering_up` is 0 and `conv_abort` is 0.
- R2: In normal mode, chip select rising after fewer than 2 falling edges leaves the mode at normal and gives no abort pulse.
- R3: In normal mode, chip select rising after 2 to 9 falling edges (both limits included) takes the sleep-light transition. `mode_code` becomes 2'b01, and `conv_abort` pulses for exactly one clock.
- R4: In normal mode, chip select rising after 10 to 15 falling edges keeps the mode at normal and pulses `conv_abort` for one clock.
- R5: In normal mode, a frame of 16 or more falling edges ends without an abort pulse and without a mode change. The edge count saturates at 16.
- R6: In partial mode, the wake-light transition fires once the 10th falling edge of a frame has been sampled while chip select is still low. `mode_code` becomes 2'b11 and `powering_up` becomes 1.
- R7: In partial mode, chip select rising after fewer than 2 falling edges leaves the mode at partial.
- R8: In partial mode, chip select rising after 2 to 9 falling edges takes the sleep-deep transition, so `mode_code` becomes 2'b10.
- R9: A wake that started from partial mode lasts exactly PART_WAKE_CYCLES clocks. The ready transition then sets `mode_code` to 2'b00 and `powered_up` to 1.
- R10: In full mode, a frame that ends before 10 falling edges leaves the mode at full. Reaching 10 falling edges with chip select still low takes the wake-deep transition to 2'b11.
- R11: A wake that started from full mode lasts exactly FULL_WAKE_CYCLES clocks, which is longer than a light wake.
- R12: During the waking state, chip-select and serial-clock activity changes nothing. `conv_abort` stays 0 and the wake timing is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| sclk | input | 1 | Serial clock, sampled on clk |
| mode_code | output | 2 | Current power state (00 normal, 01 partial, 10 full, 11 waking) |
| powering_up | output | 1 | High while a wake delay is running |
| powered_up | output | 1 | High in normal mode |
| conv_abort | output | 1 | One-clock pulse when a normal-mode conversion is cut short |

## Verification
The bench runs frames whose falling-edge counts land on each side of every window limit: 0, 1, 2, 9, 10, 12, 15, 16 and 20 edges. This separates glitch rejection, the power-down window, the abort-only window and complete frames. The same edge counts are replayed in each of the partial and full states. This shows that an identical frame length produces a different transition depending on the starting state. A frame sent while a deep wake is in progress, together with a reset issued partway through a run, shows that the wake timer can be disturbed only by reset.

// File: rtl/cs_pm_pkg.sv
package cs_pm_pkg;

    // The state encoding doubles as the externally visible mode code.
    typedef enum logic [1:0] {
        PM_NORMAL  = 2'b00,
        PM_PARTIAL = 2'b01,
        PM_FULL    = 2'b10,
        PM_WAKING  = 2'b11
    } pm_state_t;

endpackage

// File: rtl/cs_pm_frame_counter.sv
module cs_pm_frame_counter #(
    parameter int FRAME_EDGES = 16,
    localparam int CW = $clog2(FRAME_EDGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    output logic          frame_active,
    output logic          cs_rise,
    output logic [CW-1:0] edge_cnt
);

    localparam logic [CW-1:0] CNT_MAX = CW'(FRAME_EDGES);

    logic cs_q;
    logic sclk_q;
    logic sclk_fall;

    assign sclk_fall    = sclk_q & ~sclk;
    assign frame_active = ~cs_q;
    assign cs_rise      = ~cs_q & cs_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q     <= 1'b1;
            sclk_q   <= 1'b1;
            edge_cnt <= '0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
            if (cs_q && !cs_n) begin
                edge_cnt <= '0;
            end else if (!cs_n && sclk_fall && (edge_cnt < CNT_MAX)) begin
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cs_pm_wake_timer.sv
module cs_pm_wake_timer #(
    parameter int SHORT_CYCLES = 20,
    parameter int LONG_CYCLES  = 60,
    localparam int MAXC = (LONG_CYCLES > SHORT_CYCLES) ? LONG_CYCLES : SHORT_CYCLES,
    localparam int TW   = $clog2(MAXC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic use_long,
    output logic done
);

    localparam logic [TW-1:0] SHORT_LOAD = TW'(SHORT_CYCLES - 1);
    localparam logic [TW-1:0] LONG_LOAD  = TW'(LONG_CYCLES - 1);

    logic [TW-1:0] remain_q;
    logic          running_q;

    assign done = running_q && (remain_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q  <= '0;
            running_q <= 1'b0;
        end else if (start) begin
            remain_q  <= use_long ? LONG_LOAD : SHORT_LOAD;
            running_q <= 1'b1;
        end else if (running_q) begin
            if (remain_q == '0) begin
                running_q <= 1'b0;
            end else begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/cs_power_mode_ctrl.sv
module cs_power_mode_ctrl
    import cs_pm_pkg::*;
#(
    parameter int GLITCH_EDGES     = 2,
    parameter int SLEEP_EDGES      = 10,
    parameter int FRAME_EDGES      = 16,
    parameter int PART_WAKE_CYCLES = 20,
    parameter int FULL_WAKE_CYCLES = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    output logic [1:0] mode_code,
    output logic       powering_up,
    output logic       powered_up,
    output logic       conv_abort
);

    localparam int CW = $clog2(FRAME_EDGES + 1);
    localparam logic [CW-1:0] GLITCH_L = CW'(GLITCH_EDGES);
    localparam logic [CW-1:0] SLEEP_L  = CW'(SLEEP_EDGES);
    localparam logic [CW-1:0] FRAME_L  = CW'(FRAME_EDGES);

    pm_state_t     state_q, state_d;
    logic          frame_active;
    logic          cs_rise;
    logic [CW-1:0] edge_cnt;
    logic          wake_go;
    logic          wake_long;
    logic          wake_done;
    logic          abort_d;
    logic          abort_q;

    cs_pm_frame_counter #(
        .FRAME_EDGES(FRAME_EDGES)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .frame_active(frame_active),
        .cs_rise     (cs_rise),
        .edge_cnt    (edge_cnt)
    );

    cs_pm_wake_timer #(
        .SHORT_CYCLES(PART_WAKE_CYCLES),
        .LONG_CYCLES (FULL_WAKE_CYCLES)
    ) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wake_go),
        .use_long(wake_long),
        .done    (wake_done)
    );

    // Next-state decision: made on the rising edge of chip select, or when
    // a dummy frame from a sleep state reaches the wake threshold.
    always_comb begin
        state_d   = state_q;
        wake_go   = 1'b0;
        wake_long = 1'b0;
        abort_d   = 1'b0;
        unique case (state_q)
            PM_NORMAL: begin
                if (cs_rise) begin
                    if (edge_cnt >= GLITCH_L && edge_cnt < SLEEP_L) begin
                        state_d = PM_PARTIAL;       // sleep-light
                        abort_d = 1'b1;
                    end else if (edge_cnt >= SLEEP_L && edge_cnt < FRAME_L) begin
                        abort_d = 1'b1;
                    end
                end
            end
            PM_PARTIAL: begin
                if (frame_active && edge_cnt >= SLEEP_L) begin
                    state_d = PM_WAKING;            // wake-light
                    wake_go = 1'b1;
                end else if (cs_rise && edge_cnt >= GLITCH_L) begin
                    state_d = PM_FULL;              // sleep-deep
                end
            end
            PM_FULL: begin
                if (frame_active && edge_cnt >= SLEEP_L) begin
                    state_d   = PM_WAKING;          // wake-deep
                    wake_go   = 1'b1;
                    wake_long = 1'b1;
                end
            end
            PM_WAKING: begin
                if (wake_done) begin
                    state_d = PM_NORMAL;            // ready
                end
            end
            default: state_d = PM_NORMAL;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PM_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register and decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abort_q <= 1'b0;
        end else begin
            abort_q <= abort_d;
        end
    end

    always_comb begin
        mode_code   = state_q;
        powering_up = (state_q == PM_WAKING);
        powered_up  = (state_q == PM_NORMAL);
        conv_abort  = abort_q;
    end

endmodule

// File: rtl/cs_power_mode_chk.sv
module cs_power_mode_chk #(
    parameter int PART_WAKE_CYCLES = 20
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_code,
    input logic       powering_up,
    input logic       powered_up,
    input logic       conv_abort
);

    int unsigned wake_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_run_q <= 0;
        end else if (powering_up) begin
            wake_run_q <= wake_run_q + 1;
        end else begin
            wake_run_q <= 0;
        end
    end

    assert_abort_from_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |-> ($past(mode_code) == 2'b00));

    assert_abort_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |=> !conv_abort);

    assert_partial_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 2'b01 && $past(mode_code) != 2'b01) |-> ($past(mode_code) == 2'b00 && conv_abort));

    assert_full_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 2'b10 && $past(mode_code) != 2'b10) |-> ($past(mode_code) == 2'b01));

    assert_wake_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powering_up) |-> ($past(mode_code) == 2'b01 || $past(mode_code) == 2'b10));

    assert_wake_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(powering_up) |-> (powered_up && wake_run_q >= PART_WAKE_CYCLES));

    assert_no_abort_waking_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(powering_up) && powering_up) |-> !conv_abort);

endmodule

bind cs_power_mode_ctrl cs_power_mode_chk #(
    .PART_WAKE_CYCLES(PART_WAKE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_code  (mode_code),
    .powering_up(powering_up),
    .powered_up (powered_up),
    .conv_abort (conv_abort)
);

// File: tb/cs_power_mode_ctrl_bench.sv
module cs_power_mode_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PART_CYC   = 20;
    localparam int FULL_CYC   = 60;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n  = 1'b1;
    logic       sclk  = 1'b1;
    logic [1:0] mode_code;
    logic       powering_up;
    logic       powered_up;
    logic       conv_abort;

    cs_power_mode_ctrl #(
        .PART_WAKE_CYCLES(PART_CYC),
        .FULL_WAKE_CYCLES(FULL_CYC)
    ) u_cs_power_mode_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .mode_code  (mode_code),
        .powering_up(powering_up),
        .powered_up (powered_up),
        .conv_abort (conv_abort)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles   = 0;
    bit    done_flag = 1'b0;
    bit    abort_seen = 1'b0;
    string cur_tag = "R1";

    // Behavioural reference: 0 normal, 1 partial, 2 full, 3 waking
    int m_state = 0;
    int m_edges = 0;
    int m_wait  = 0;
    bit m_low   = 1'b0;
    bit m_prev_sclk = 1'b1;
    bit m_abort = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_edges = 0; m_wait = 0;
            m_low = 1'b0; m_prev_sclk = 1'b1; m_abort = 1'b0;
        end else begin
            int nxt;
            nxt = m_state;
            m_abort = 1'b0;
            if (m_state == 3) begin
                m_wait = m_wait - 1;
                if (m_wait == 0) nxt = 0;
            end else if (m_low && m_edges >= 10 && (m_state == 1 || m_state == 2)) begin
                m_wait = (m_state == 1) ? PART_CYC : FULL_CYC;
                nxt = 3;
            end else if (m_low && cs_n) begin
                if (m_state == 0) begin
                    if (m_edges >= 2 && m_edges <= 9) begin nxt = 1; m_abort = 1'b1; end
                    else if (m_edges >= 10 && m_edges <= 15) m_abort = 1'b1;
                end else if (m_state == 1 && m_edges >= 2) begin
                    nxt = 2;
                end
            end
            m_state = nxt;
            if (!cs_n && !m_low) m_edges = 0;
            else if (!cs_n && m_prev_sclk && !sclk && m_edges < 16) m_edges = m_edges + 1;
            m_low = !cs_n;
            m_prev_sclk = sclk;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            n_checks++;
            if (conv_abort) abort_seen = 1'b1;
            if (mode_code != 2'(m_state) || powering_up != (m_state == 3) ||
                powered_up != (m_state == 0) || conv_abort != m_abort) begin
                n_errors++;
                $display("FAIL %s cycle %0d: mode=%0d/%0d pu=%0b/%0b ready=%0b/%0b abort=%0b/%0b (actual/expected)",
                         cur_tag, cycles, mode_code, m_state, powering_up, (m_state == 3),
                         powered_up, (m_state == 0), conv_abort, m_abort);
            end
        end
    end

    task automatic report();
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done_flag) begin
            n_errors++;
            $display("FAIL watchdog: run did not finish, actual cycles=%0d expected below 50000", cycles);
            report();
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic frame(input int n_edges);
        @(negedge clk);
        abort_seen = 1'b0;
        cs_n = 1'b0;
        idle(2);
        for (int i = 0; i < n_edges; i++) begin
            sclk = 1'b0;
            idle(2);
            sclk = 1'b1;
            idle(2);
        end
        cs_n = 1'b1;
        idle(3);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        check("R1", "mode after reset", mode_code, 0);
        check("R1", "powered_up after reset", powered_up, 1);
        check("R1", "powering_up after reset", powering_up, 0);
        check("R1", "abort after reset", conv_abort, 0);

        cur_tag = "R2";
        frame(0); check("R2", "mode 0-edge glitch", mode_code, 0); check("R2", "abort 0-edge", abort_seen, 0);
        frame(1); check("R2", "mode 1-edge glitch", mode_code, 0); check("R2", "abort 1-edge", abort_seen, 0);

        cur_tag = "R5";
        frame(16); check("R5", "mode full frame", mode_code, 0); check("R5", "abort full frame", abort_seen, 0);
        frame(20); check("R5", "mode long frame", mode_code, 0); check("R5", "abort long frame", abort_seen, 0);

        cur_tag = "R4";
        frame(10); check("R4", "mode 10 edges", mode_code, 0); check("R4", "abort 10 edges", abort_seen, 1);
        frame(15); check("R4", "mode 15 edges", mode_code, 0); check("R4", "abort 15 edges", abort_seen, 1);

        cur_tag = "R3";
        frame(9); check("R3", "mode 9 edges", mode_code, 1); check("R3", "abort 9 edges", abort_seen, 1);

        cur_tag = "R7";
        frame(1); check("R7", "partial glitch", mode_code, 1);

        cur_tag = "R6";
        frame(12);
        check("R6", "mode after wake frame", mode_code, 3);
        check("R6", "powering_up", powering_up, 1);
        cur_tag = "R9";
        idle(25);
        check("R9", "mode after light wake", mode_code, 0);
        check("R9", "powered_up after light wake", powered_up, 1);

        cur_tag = "R3";
        frame(2); check("R3", "mode 2 edges", mode_code, 1); check("R3", "abort 2 edges", abort_seen, 1);

        cur_tag = "R8";
        frame(9); check("R8", "mode partial 9 edges", mode_code, 2);

        cur_tag = "R10";
        frame(1); check("R10", "full glitch", mode_code, 2);
        frame(9); check("R10", "full 9 edges", mode_code, 2);
        frame(10); check("R10", "full wake frame", mode_code, 3);

        cur_tag = "R12";
        frame(5);
        check("R12", "mode during waking frame", mode_code, 3);
        check("R12", "abort during waking", abort_seen, 0);

        cur_tag = "R11";
        check("R11", "still waking past light delay", powering_up, 1);
        idle(40);
        check("R11", "mode after deep wake", mode_code, 0);

        cur_tag = "R1";
        frame(4); check("R3", "mode 4 edges", mode_code, 1);
        @(negedge clk);
        #2 rst_n = 1'b0;
        idle(2);
        check("R1", "mode during mid-run reset", mode_code, 0);
        rst_n = 1'b1;
        idle(2);
        check("R1", "mode after mid-run reset", mode_code, 0);
        check("R1", "powered_up after mid-run reset", powered_up, 1);

        report();
    end

endmodule